// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block caches a small set of virtual-to-physical page translations and answers lookups against all of them at once. Every entry holds a virtual page number as its tag and a page table entry as its value, together with an entry-valid bit of its own. A lookup presents a virtual address. One cycle later the block reports one of three outcomes. On a hit it returns the stored page table entry and the physical address, made from the frame number and the untouched page offset. On a miss it raises a miss exception. If the matching entry marks its page as not present, it raises an invalid-page exception.

The block never walks page tables. When a miss exception is raised, a software handler finds the translation and installs it through the refill port, which gives an entry index, a tag and a value. On a context switch the flush input wipes every translation in a single cycle.

The page table entry value is `PFN_W + 4` bits wide. Bit 0 is the page-present bit. Bits 3:1 are permission bits, stored and returned unchanged. The upper bits hold the physical frame number.

Top module: `tlb_sw_refill`

## Requirements
- R1: After reset every entry is invalid, and `rsp_valid`, `rsp_hit`, `rsp_miss_exc`, `rsp_inval_exc`, `rsp_multi`, `rsp_paddr` and `rsp_pte` are all zero.
- R2: A cycle with `lk_req` high produces `rsp_valid` high in the following cycle, and exactly one of `rsp_hit`, `rsp_miss_exc` and `rsp_inval_exc` is high with it.
- R3: When the selected entry's tag equals the lookup's virtual page number (`lk_vaddr[VA_W-1:OFF_W]`) and bit 0 of its value is 1, `rsp_hit` is high, `rsp_pte` is the stored value, and `rsp_paddr` is {value bits PTE_W-1:4, `lk_vaddr[OFF_W-1:0]`}.
- R4: When no entry with its entry-valid bit set has a matching tag, `rsp_miss_exc` is high and `rsp_pte` and `rsp_paddr` are zero.
- R5: When the selected matching entry has bit 0 of its value clear, `rsp_inval_exc` is high, `rsp_hit` is low, `rsp_pte` is the stored value and `rsp_paddr` is zero.
- R6: When several valid entries match, the lowest-indexed one is selected and `rsp_multi` is high. `rsp_multi` is low otherwise.
- R7: A refill with `wr_en` high replaces entry `wr_idx` (tag and value) and sets its entry-valid bit, effective from the next cycle. A lookup in the same cycle sees the old contents.
- R8: `flush` clears every entry-valid bit, effective from the next cycle. A lookup in the same cycle sees the old contents. A refill in the same cycle as a flush is kept.
- R9: In a cycle after one with `lk_req` low, `rsp_valid`, all outcome flags, `rsp_paddr` and `rsp_pte` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| wr_en | input | 1 | Refill write enable |
| wr_idx | input | IDX_W | Entry to replace |
| wr_vpn | input | VPN_W | Tag to install |
| wr_pte | input | PTE_W | Page table entry to install |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation found and page present |
| rsp_miss_exc | output | 1 | Miss exception |
| rsp_inval_exc | output | 1 | Invalid-page exception |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | PA_W | Physical address on hit |
| rsp_pte | output | PTE_W | Selected page table entry |

## Verification
The hardest situations to reach are the ones where two things happen in the same cycle: a lookup together with a refill of the very entry it matches, and a lookup together with a flush. Only there does "old contents seen" differ from "new contents seen". The bench drives lookup, refill and flush from a single per-cycle task, so these collisions are placed on purpose. A separate refill installs a duplicate tag below an existing one, once with the page-present bit clear, to produce multi-hits whose lowest-index winner is either a hit or an invalid-page exception. Around these cases, full sweeps of every virtual address (page number and offset) run with an empty buffer, a loaded buffer and a flushed buffer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PRESENT_BIT = 0;
    localparam int PERM_LO     = 1;
    localparam int PFN_LO      = 4;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_INVAL = 2'd3
    } outcome_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [VPN_W-1:0]              vpn,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == vpn);
    end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic               multi
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any   = |req;
        multi = |(req & (req - ENTRIES'(1)));
    end
endmodule

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int PTE_W  = PFN_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PTE_W-1:0] wr_pte,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss_exc,
    output logic             rsp_inval_exc,
    output logic             rsp_multi,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [PTE_W-1:0] rsp_pte
);
    import tlb_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PTE_W-1:0] pte;
        logic                          rsp_v;
        outcome_e                      outc;
        logic                          multi;
        logic [PA_W-1:0]               pa;
        logic [PTE_W-1:0]              rpte;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] match;
    logic               any_match;
    logic [IDX_W-1:0]   sel_idx;
    logic               multi_raw;
    logic [PTE_W-1:0]   sel_pte;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .tags  (s_q.tag),
        .vld   (s_q.vld),
        .vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .match (match)
    );

    tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
        .req   (match),
        .any   (any_match),
        .idx   (sel_idx),
        .multi (multi_raw)
    );

    assign sel_pte = s_q.pte[sel_idx];

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = lk_req;
        s_d.outc  = OUT_NONE;
        s_d.multi = 1'b0;
        s_d.pa    = '0;
        s_d.rpte  = '0;

        // lookup reads the registered contents: same-cycle writes are not seen
        if (lk_req) begin
            s_d.multi = multi_raw;
            if (!any_match) begin
                s_d.outc = OUT_MISS;
            end else if (sel_pte[PRESENT_BIT]) begin
                s_d.outc = OUT_HIT;
                s_d.rpte = sel_pte;
                s_d.pa   = {sel_pte[PTE_W-1:PFN_LO], lk_vaddr[OFF_W-1:0]};
            end else begin
                s_d.outc = OUT_INVAL;
                s_d.rpte = sel_pte;
            end
        end

        if (flush) s_d.vld = '0;

        if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            s_d.vld[wr_idx] = 1'b1;
            s_d.tag[wr_idx] = wr_vpn;
            s_d.pte[wr_idx] = wr_pte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.outc  <= OUT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid     = s_q.rsp_v;
    assign rsp_hit       = (s_q.outc == OUT_HIT);
    assign rsp_miss_exc  = (s_q.outc == OUT_MISS);
    assign rsp_inval_exc = (s_q.outc == OUT_INVAL);
    assign rsp_multi     = s_q.multi;
    assign rsp_paddr     = s_q.pa;
    assign rsp_pte       = s_q.rpte;
endmodule

// File: rtl/tlb_sw_refill_chk.sv
module tlb_sw_refill_chk #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int PTE_W  = PFN_W + 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [VPN_W-1:0] wr_vpn,
    input logic [PTE_W-1:0] wr_pte,
    input logic             flush,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss_exc,
    input logic             rsp_inval_exc,
    input logic             rsp_multi,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [PTE_W-1:0] rsp_pte
);
    logic unused_ok;
    assign unused_ok = ^{wr_idx, wr_vpn, wr_pte};

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_valid && $countones({rsp_hit, rsp_miss_exc, rsp_inval_exc}) == 1));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_miss_exc && !rsp_inval_exc
                     && !rsp_multi && rsp_paddr == '0 && rsp_pte == '0));

    // R3
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || (rsp_pte[0] &&
                    rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]) &&
                    rsp_paddr[PA_W-1:OFF_W] == rsp_pte[PTE_W-1:4])));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss_exc |-> (rsp_paddr == '0 && rsp_pte == '0 && !rsp_multi));

    // R5
    inval_nopresent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_inval_exc |-> (!rsp_pte[0] && rsp_paddr == '0));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !wr_en) ##1 (lk_req && !wr_en && !flush) |=> rsp_miss_exc);
endmodule

bind tlb_sw_refill tlb_sw_refill_chk #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tlb_sw_refill_tb.sv
module tlb_sw_refill_tb;
    localparam int ENTRIES = 8;
    localparam int VPN_W   = 5;
    localparam int PFN_W   = 5;
    localparam int OFF_W   = 3;
    localparam int IDX_W   = 3;
    localparam int VA_W    = VPN_W + OFF_W;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int PTE_W   = PFN_W + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_req = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PTE_W-1:0] wr_pte = '0;
    logic             flush = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_miss_exc, rsp_inval_exc, rsp_multi;
    logic [PA_W-1:0]  rsp_paddr;
    logic [PTE_W-1:0] rsp_pte;

    int checks = 0;
    int fails  = 0;

    logic [VPN_W-1:0] m_tag [ENTRIES];
    logic [PTE_W-1:0] m_pte [ENTRIES];
    logic             m_vld [ENTRIES];

    always #5 clk = ~clk;

    tlb_sw_refill #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pte(wr_pte), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss_exc(rsp_miss_exc),
        .rsp_inval_exc(rsp_inval_exc), .rsp_multi(rsp_multi),
        .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte)
    );

    task automatic check(input string req, input logic [PA_W+PTE_W+5:0] act,
                         input logic [PA_W+PTE_W+5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; expectation comes from the model before the update.
    task automatic step(input string ctx, input logic lk, input logic [VA_W-1:0] va,
                        input logic we, input int idx, input logic [VPN_W-1:0] vpn,
                        input logic [PTE_W-1:0] pte, input logic fl);
        logic e_v, e_h, e_m, e_i, e_mu;
        logic [PA_W-1:0] e_pa;
        logic [PTE_W-1:0] e_pte;
        int first, cnt;
        string tag;
        first = -1; cnt = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_vld[i] && m_tag[i] == va[VA_W-1:OFF_W]) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        e_v = lk; e_h = 0; e_m = 0; e_i = 0; e_mu = 0; e_pa = '0; e_pte = '0;
        tag = lk ? "R2" : "R9";
        if (lk) begin
            e_mu = (cnt > 1);
            if (first < 0) begin
                e_m = 1; tag = "R4";
            end else if (m_pte[first][0]) begin
                e_h = 1; e_pte = m_pte[first];
                e_pa = {m_pte[first][PTE_W-1:4], va[OFF_W-1:0]};
                tag = e_mu ? "R6" : "R3";
            end else begin
                e_i = 1; e_pte = m_pte[first];
                tag = e_mu ? "R6" : "R5";
            end
        end
        lk_req = lk; lk_vaddr = va; wr_en = we; wr_idx = IDX_W'(idx);
        wr_vpn = vpn; wr_pte = pte; flush = fl;
        @(posedge clk);
        if (fl) for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
        if (we) begin m_vld[idx] = 1'b1; m_tag[idx] = vpn; m_pte[idx] = pte; end
        @(negedge clk);
        lk_req = 0; wr_en = 0; flush = 0;
        check({tag, " ", ctx},
              {rsp_valid, rsp_hit, rsp_miss_exc, rsp_inval_exc, rsp_multi, rsp_paddr, rsp_pte, 1'b0},
              {e_v, e_h, e_m, e_i, e_mu, e_pa, e_pte, 1'b0});
    endtask

    task automatic sweep(input string ctx);
        for (int a = 0; a < (1 << VA_W); a++) step(ctx, 1, VA_W'(a), 0, 0, '0, '0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_pte[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 reset", {rsp_valid, rsp_hit, rsp_miss_exc, rsp_inval_exc, rsp_multi, rsp_paddr, rsp_pte, 1'b0}, '0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {rsp_valid, rsp_hit, rsp_miss_exc, rsp_inval_exc, rsp_multi, rsp_paddr, rsp_pte, 1'b0}, '0);
        // R1/R4: empty buffer misses everywhere
        sweep("empty");
        step("idle", 0, '0, 0, 0, '0, '0, 0);  // R9
        // R7: fill all entries; entry 5 has its page-present bit clear
        for (int i = 0; i < ENTRIES; i++)
            step("fill", 0, '0, 1, i, VPN_W'(i * 3 + 1),
                 {PFN_W'((i * 7 + 2) % 32), 3'(i), (i != 5)}, 0);
        sweep("loaded");  // R3 R4 R5
        // R7: lookup of entry 2's tag while entry 2 is rewritten sees the old tag
        step("R7 same-cycle", 1, {VPN_W'(7), 3'd5}, 1, 2, VPN_W'(19), {PFN_W'(30), 3'd6, 1'b1}, 0);
        step("R7 old tag gone", 1, {VPN_W'(7), 3'd1}, 0, 0, '0, '0, 0);
        // R6: entries 2 and 6 share tag 19, entry 2 wins
        step("R6 lowest wins", 1, {VPN_W'(19), 3'd7}, 0, 0, '0, '0, 0);
        // R6 with R5: entry 0 now also tag 19, page not present
        step("R6 load dup", 0, '0, 1, 0, VPN_W'(19), {PFN_W'(9), 3'd2, 1'b0}, 0);
        step("R6 winner invalid", 1, {VPN_W'(19), 3'd3}, 0, 0, '0, '0, 0);
        // R8: lookup in the flush cycle sees old contents, afterwards all miss
        step("R8 same-cycle flush", 1, {VPN_W'(4), 3'd2}, 0, 0, '0, '0, 1);
        sweep("flushed");
        // R8: refill in the flush cycle survives
        step("R8 refill", 0, '0, 1, 1, VPN_W'(4), {PFN_W'(3), 3'd1, 1'b1}, 0);
        step("R8 flush+refill", 0, '0, 1, 3, VPN_W'(10), {PFN_W'(17), 3'd4, 1'b1}, 1);
        step("R8 kept", 1, {VPN_W'(10), 3'd6}, 0, 0, '0, '0, 0);
        step("R8 cleared", 1, {VPN_W'(4), 3'd6}, 0, 0, '0, '0, 0);
        step("idle end", 0, '0, 0, 0, '0, '0, 0);  // R9
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule